// File: doc/BRIEF.md
# Stream trigger fetch scheduler

This block decides on which clock a frame of the scheduled traffic class is pulled from memory for transmission. It holds a small table of programmed streams. Each entry names a stream by its destination MAC address and VLAN ID. Each entry also carries a trigger offset in nanoseconds, counted from the start of the gate schedule cycle, and a burst of one to four frames. When the cycle-relative time reaches an entry's offset, the block serves that entry once. If the scheduled gate is open at that moment, it issues one fetch request per clock for the burst. If the gate is closed, the trigger is dropped for that cycle and counted as missed.

When no entry is valid, the block runs in continuous mode. In that mode it requests a frame on every clock where the scheduled gate is open and the scheduled queue reports a frame waiting. Descriptor handling and memory access belong to the consumer of the request outputs. The configuration port writes one table entry per clock.

Top module: `fts_top`

## Requirements
- R1: After reset, `fetch_req` is low, `miss_count` is zero, `discrete_mode` is low, `cfg_err` is low and no entry is armed. Before the first `cycle_start`, no trigger can fire.
- R2: While no entry is valid, `fetch_req` is high one clock after each clock on which `st_gate_open` and `cont_avail` were both high. During that request `fetch_idx`, `fetch_mac` and `fetch_vid` are zero.
- R3: A write with `cfg_we` high stores the entry at `cfg_idx` on that clock edge. `cfg_burst` encodes the burst as frames minus one (0 means 1 frame, 3 means 4 frames). `discrete_mode` is high from the clock after a valid entry is stored and stays high while any entry is valid.
- R4: An entry becomes due when it is valid, its offset is below `cycle_time`, `cur_time` is greater than or equal to its offset, and it has not yet been served in this cycle. A served entry is not served again until the next `cycle_start`.
- R5: A due entry is taken on a clock where no burst is running. If `st_gate_open` is high on that clock, requests are issued on the following clocks: one edge later the first burst slot is evaluated, and each slot raises `fetch_req` one clock after it. Each request carries the entry's index, MAC and VLAN ID. The number of slots equals the burst size.
- R6: If `st_gate_open` is low on the clock an entry is taken, no burst starts. `miss_count` then increases by one and saturates at its all-ones value.
- R7: If `st_gate_open` is low at a burst slot, the rest of that burst is abandoned and no request is issued for that slot.
- R8: Entries due on the same clock are served in ascending index order. The next one is taken on the clock after the previous burst ends.
- R9: A valid entry whose offset is greater than or equal to `cycle_time` never triggers, and `cfg_err` is high while such an entry exists.
- R10: A clock with `cycle_start` high aborts any running burst, re-arms every entry, and leaves `fetch_req` low on the following clock.
- R11: In a burst slot where the stream's `frame_avail` bit is low, the slot is used up but no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | One-clock pulse at the start of each gate schedule cycle |
| cycle_time | input | 32 | Gate schedule cycle length in ns |
| cur_time | input | 32 | Time since the current cycle start, in ns |
| st_gate_open | input | 1 | Scheduled-class gate is open |
| cont_avail | input | 1 | Scheduled queue holds a frame (continuous mode) |
| frame_avail | input | 8 | Per-stream frame-available flags |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 3 | Table entry written |
| cfg_valid | input | 1 | Valid bit of the written entry |
| cfg_dst_mac | input | 48 | Destination MAC of the written entry |
| cfg_vid | input | 12 | VLAN ID of the written entry |
| cfg_offset | input | 32 | Trigger offset in ns of the written entry |
| cfg_burst | input | 2 | Burst size minus one of the written entry |
| fetch_req | output | 1 | Fetch request, one frame per high clock |
| fetch_idx | output | 3 | Entry index of the request |
| fetch_mac | output | 48 | Destination MAC of the request |
| fetch_vid | output | 12 | VLAN ID of the request |
| discrete_mode | output | 1 | At least one entry is valid |
| cfg_err | output | 1 | A valid entry has an offset outside the cycle |
| miss_count | output | 8 | Saturating count of triggers skipped on a closed gate |

## Verification
The tightest collision is a `cycle_start` pulse that lands on the same clock as a burst slot. The re-arm has to win: the slot is dropped, the burst ends, and the entry can fire again in the new cycle. The bench provokes this with an entry whose offset sits 30 ns before the end of a cycle and whose burst is four frames long. With the gate held open to the cycle end, two requests go out before the pulse cuts the burst. A second overlap is two entries sharing one offset. The bench expects the lower index's whole burst first, then the higher index's burst after a one-clock take gap. A behavioural model makes both judgements on every clock.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int TIME_W  = 32;
  localparam int MAC_W   = 48;
  localparam int VID_W   = 12;
  localparam int BURST_W = 2;

  typedef struct packed {
    logic               valid;
    logic [MAC_W-1:0]   mac;
    logic [VID_W-1:0]   vid;
    logic [TIME_W-1:0]  offset;
    logic [BURST_W-1:0] burst_m1;
  } stream_entry_t;

  // Offset lies inside the running schedule cycle.
  function automatic logic offset_in_range(input logic [TIME_W-1:0] offset,
                                           input logic [TIME_W-1:0] cyc_len);
    return offset < cyc_len;
  endfunction

  // Cycle-relative time has reached the trigger point.
  function automatic logic trigger_reached(input logic [TIME_W-1:0] now,
                                           input logic [TIME_W-1:0] offset);
    return now >= offset;
  endfunction

  // Encoded burst (frames minus one) to frame count.
  function automatic logic [BURST_W:0] burst_frames(input logic [BURST_W-1:0] enc);
    return {1'b0, enc} + 1'b1;
  endfunction

endpackage

// File: rtl/fts_stream_table.sv
module fts_stream_table import fts_pkg::*; #(
  parameter int NUM_STREAMS = 8,
  parameter int IDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  stream_entry_t       wr_entry,
  input  logic [TIME_W-1:0]   cycle_time,
  output logic [TIME_W-1:0]   ent_offset [NUM_STREAMS],
  output logic [MAC_W-1:0]    ent_mac    [NUM_STREAMS],
  output logic [VID_W-1:0]    ent_vid    [NUM_STREAMS],
  output logic [BURST_W-1:0]  ent_burst  [NUM_STREAMS],
  output logic [NUM_STREAMS-1:0] ent_live,
  output logic                any_valid,
  output logic                range_err
);

  logic [NUM_STREAMS-1:0] valid_q;
  logic [NUM_STREAMS-1:0] bad_range;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g]    <= 1'b0;
        ent_offset[g] <= '0;
        ent_mac[g]    <= '0;
        ent_vid[g]    <= '0;
        ent_burst[g]  <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        valid_q[g]    <= wr_entry.valid;
        ent_offset[g] <= wr_entry.offset;
        ent_mac[g]    <= wr_entry.mac;
        ent_vid[g]    <= wr_entry.vid;
        ent_burst[g]  <= wr_entry.burst_m1;
      end
    end

    assign ent_live[g]  = valid_q[g] &&  offset_in_range(ent_offset[g], cycle_time);
    assign bad_range[g] = valid_q[g] && !offset_in_range(ent_offset[g], cycle_time);
  end

  assign any_valid = |valid_q;
  assign range_err = |bad_range;

endmodule

// File: rtl/fts_trigger_arb.sv
module fts_trigger_arb import fts_pkg::*; #(
  parameter int NUM_STREAMS = 8,
  parameter int IDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cycle_start,
  input  logic [TIME_W-1:0]      cur_time,
  input  logic [TIME_W-1:0]      ent_offset [NUM_STREAMS],
  input  logic [NUM_STREAMS-1:0] ent_live,
  input  logic                   take_en,
  output logic                   take_valid,
  output logic [IDX_W-1:0]       take_idx
);

  logic [NUM_STREAMS-1:0] armed_q;
  logic [NUM_STREAMS-1:0] due;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_due
    assign due[g] = armed_q[g] && ent_live[g] && trigger_reached(cur_time, ent_offset[g]);
  end

  // Lowest index wins among entries due together.
  always_comb begin
    take_idx = '0;
    for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
      if (due[i]) take_idx = IDX_W'(i);
    end
  end

  assign take_valid = take_en && (|due);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= '0;
    end else if (cycle_start) begin
      armed_q <= '1;
    end else if (take_valid) begin
      armed_q[take_idx] <= 1'b0;
    end
  end

endmodule

// File: rtl/fts_burst_engine.sv
module fts_burst_engine import fts_pkg::*; #(
  parameter int NUM_STREAMS = 8,
  parameter int MISS_W = 8,
  parameter int IDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cycle_start,
  input  logic                   discrete,
  input  logic                   st_gate_open,
  input  logic                   cont_avail,
  input  logic [NUM_STREAMS-1:0] frame_avail,
  input  logic [MAC_W-1:0]       ent_mac   [NUM_STREAMS],
  input  logic [VID_W-1:0]       ent_vid   [NUM_STREAMS],
  input  logic [BURST_W-1:0]     ent_burst [NUM_STREAMS],
  input  logic                   take_valid,
  input  logic [IDX_W-1:0]       take_idx,
  output logic                   busy,
  output logic                   miss_evt,
  output logic                   fetch_req,
  output logic [IDX_W-1:0]       fetch_idx,
  output logic [MAC_W-1:0]       fetch_mac,
  output logic [VID_W-1:0]       fetch_vid,
  output logic [MISS_W-1:0]      miss_count
);

  logic [IDX_W-1:0]   cur_q;
  logic [BURST_W:0]   left_q;

  assign miss_evt = take_valid && !st_gate_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cur_q      <= '0;
      left_q     <= '0;
      fetch_req  <= 1'b0;
      fetch_idx  <= '0;
      fetch_mac  <= '0;
      fetch_vid  <= '0;
      miss_count <= '0;
    end else if (cycle_start) begin
      busy      <= 1'b0;
      fetch_req <= 1'b0;
    end else if (!discrete) begin
      busy      <= 1'b0;
      fetch_req <= st_gate_open && cont_avail;
      fetch_idx <= '0;
      fetch_mac <= '0;
      fetch_vid <= '0;
    end else if (busy) begin
      if (st_gate_open) begin
        fetch_req <= frame_avail[cur_q];
        fetch_idx <= cur_q;
        fetch_mac <= ent_mac[cur_q];
        fetch_vid <= ent_vid[cur_q];
        left_q    <= left_q - 1'b1;
        busy      <= (left_q != 1);
      end else begin
        busy      <= 1'b0;
        fetch_req <= 1'b0;
      end
    end else begin
      fetch_req <= 1'b0;
      if (take_valid) begin
        if (st_gate_open) begin
          busy   <= 1'b1;
          cur_q  <= take_idx;
          left_q <= burst_frames(ent_burst[take_idx]);
        end else if (miss_count != {MISS_W{1'b1}}) begin
          miss_count <= miss_count + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fts_top.sv
module fts_top import fts_pkg::*; #(
  parameter int NUM_STREAMS = 8,
  parameter int MISS_W = 8,
  parameter int IDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cycle_start,
  input  logic [TIME_W-1:0]      cycle_time,
  input  logic [TIME_W-1:0]      cur_time,
  input  logic                   st_gate_open,
  input  logic                   cont_avail,
  input  logic [NUM_STREAMS-1:0] frame_avail,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic                   cfg_valid,
  input  logic [MAC_W-1:0]       cfg_dst_mac,
  input  logic [VID_W-1:0]       cfg_vid,
  input  logic [TIME_W-1:0]      cfg_offset,
  input  logic [BURST_W-1:0]     cfg_burst,
  output logic                   fetch_req,
  output logic [IDX_W-1:0]       fetch_idx,
  output logic [MAC_W-1:0]       fetch_mac,
  output logic [VID_W-1:0]       fetch_vid,
  output logic                   discrete_mode,
  output logic                   cfg_err,
  output logic [MISS_W-1:0]      miss_count
);

  stream_entry_t          wr_entry;
  logic [TIME_W-1:0]      ent_offset [NUM_STREAMS];
  logic [MAC_W-1:0]       ent_mac    [NUM_STREAMS];
  logic [VID_W-1:0]       ent_vid    [NUM_STREAMS];
  logic [BURST_W-1:0]     ent_burst  [NUM_STREAMS];
  logic [NUM_STREAMS-1:0] ent_live;
  logic                   engine_busy;
  logic                   take_en;
  logic                   take_evt;
  logic [IDX_W-1:0]       take_idx;
  logic                   miss_evt;

  assign wr_entry = '{valid: cfg_valid, mac: cfg_dst_mac, vid: cfg_vid,
                      offset: cfg_offset, burst_m1: cfg_burst};

  fts_stream_table #(.NUM_STREAMS(NUM_STREAMS), .IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_idx     (cfg_idx),
    .wr_entry   (wr_entry),
    .cycle_time (cycle_time),
    .ent_offset (ent_offset),
    .ent_mac    (ent_mac),
    .ent_vid    (ent_vid),
    .ent_burst  (ent_burst),
    .ent_live   (ent_live),
    .any_valid  (discrete_mode),
    .range_err  (cfg_err)
  );

  assign take_en = discrete_mode && !engine_busy && !cycle_start;

  fts_trigger_arb #(.NUM_STREAMS(NUM_STREAMS), .IDX_W(IDX_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_start (cycle_start),
    .cur_time    (cur_time),
    .ent_offset  (ent_offset),
    .ent_live    (ent_live),
    .take_en     (take_en),
    .take_valid  (take_evt),
    .take_idx    (take_idx)
  );

  fts_burst_engine #(.NUM_STREAMS(NUM_STREAMS), .MISS_W(MISS_W), .IDX_W(IDX_W)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .cycle_start  (cycle_start),
    .discrete     (discrete_mode),
    .st_gate_open (st_gate_open),
    .cont_avail   (cont_avail),
    .frame_avail  (frame_avail),
    .ent_mac      (ent_mac),
    .ent_vid      (ent_vid),
    .ent_burst    (ent_burst),
    .take_valid   (take_evt),
    .take_idx     (take_idx),
    .busy         (engine_busy),
    .miss_evt     (miss_evt),
    .fetch_req    (fetch_req),
    .fetch_idx    (fetch_idx),
    .fetch_mac    (fetch_mac),
    .fetch_vid    (fetch_vid),
    .miss_count   (miss_count)
  );

endmodule

// File: rtl/fts_checker.sv
module fts_checker #(
  parameter int MISS_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cycle_start,
  input logic              st_gate_open,
  input logic              fetch_req,
  input logic              discrete_mode,
  input logic [MISS_W-1:0] miss_count,
  input logic              take_evt,
  input logic              miss_evt
);

  logic [2:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        run_q <= '0;
    else if (fetch_req && discrete_mode) run_q <= run_q + 1'b1;
    else                               run_q <= '0;
  end

  // R5 / R2: a request only follows a clock with the gate open
  p_req_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> $past(st_gate_open));

  // R5: no discrete burst longer than four frames
  p_burst_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && discrete_mode) |-> (run_q < 3'd4));

  // R10: the clock after a cycle start carries no request
  p_quiet_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> !fetch_req);

  // R6: a miss adds exactly one until saturation
  p_miss_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && (miss_count != {MISS_W{1'b1}})) |=> (miss_count == $past(miss_count) + 1'b1));

  // R6: a take on an open gate leaves the miss count alone
  p_no_miss_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && st_gate_open) |=> $stable(miss_count));

endmodule

bind fts_top fts_checker #(.MISS_W(MISS_W)) u_fts_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cycle_start   (cycle_start),
  .st_gate_open  (st_gate_open),
  .fetch_req     (fetch_req),
  .discrete_mode (discrete_mode),
  .miss_count    (miss_count),
  .take_evt      (take_evt),
  .miss_evt      (miss_evt)
);

// File: tb/tb_fts_top.sv
`timescale 1ns/1ps
module tb_fts_top;

  localparam int CYC_CLKS = 100;
  localparam int STEP     = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cycle_start = 1'b0;
  logic [31:0] cycle_time = 32'd1000;
  logic [31:0] cur_time = '0;
  logic        st_gate_open = 1'b0;
  logic        cont_avail = 1'b0;
  logic [7:0]  frame_avail = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic        cfg_valid = 1'b0;
  logic [47:0] cfg_dst_mac = '0;
  logic [11:0] cfg_vid = '0;
  logic [31:0] cfg_offset = '0;
  logic [1:0]  cfg_burst = '0;
  logic        fetch_req;
  logic [2:0]  fetch_idx;
  logic [47:0] fetch_mac;
  logic [11:0] fetch_vid;
  logic        discrete_mode;
  logic        cfg_err;
  logic [7:0]  miss_count;

  fts_top dut (.*);

  always #2.5 clk = ~clk;

  int    vectors = 0;
  int    miscompares = 0;
  string phase = "R1";

  // ---------------- stimulus time base ----------------
  bit drv_on = 0;
  bit fa_toggle = 0;
  bit cont_toggle = 0;
  int g_lo = 100;
  int g_hi = 600;
  int tick = 0;

  always @(negedge clk) begin
    if (drv_on) begin
      cycle_start  = (tick == 0);
      cur_time     = 32'(tick * STEP);
      st_gate_open = (int'(cur_time) >= g_lo) && (int'(cur_time) < g_hi);
      cont_avail   = cont_toggle ? tick[1] : 1'b1;
      frame_avail  = 8'hFF;
      if (fa_toggle) frame_avail[0] = tick[0];
      tick = (tick == CYC_CLKS - 1) ? 0 : tick + 1;
    end
  end

  // ---------------- behavioural reference ----------------
  bit          m_valid [8];
  int unsigned m_off   [8];
  int          m_cnt   [8];
  logic [47:0] m_mac   [8];
  logic [11:0] m_vid   [8];
  bit          m_armed [8];
  bit          m_busy = 0;
  int          m_cur = 0;
  int          m_left = 0;
  bit          m_req = 0;
  int          m_idx = 0;
  logic [47:0] m_omac = '0;
  logic [11:0] m_ovid = '0;
  int          m_miss = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_valid[i]) begin m_valid[i] = 0; m_armed[i] = 0; end
      m_busy = 0; m_req = 0; m_miss = 0; m_idx = 0; m_omac = '0; m_ovid = '0;
    end else begin
      bit disc;
      disc = 0;
      foreach (m_valid[i]) if (m_valid[i]) disc = 1;
      if (cycle_start) begin
        foreach (m_armed[i]) m_armed[i] = 1;
        m_busy = 0; m_req = 0;
      end else if (!disc) begin
        m_busy = 0; m_req = st_gate_open && cont_avail;
        m_idx = 0; m_omac = '0; m_ovid = '0;
      end else if (m_busy) begin
        if (st_gate_open) begin
          m_req = frame_avail[m_cur]; m_idx = m_cur;
          m_omac = m_mac[m_cur]; m_ovid = m_vid[m_cur];
          m_left--;
          if (m_left == 0) m_busy = 0;
        end else begin
          m_busy = 0; m_req = 0;
        end
      end else begin
        int pick;
        m_req = 0;
        pick = -1;
        for (int i = 7; i >= 0; i--)
          if (m_valid[i] && m_armed[i] && m_off[i] < cycle_time && cur_time >= m_off[i])
            pick = i;
        if (pick >= 0) begin
          m_armed[pick] = 0;
          if (st_gate_open) begin m_busy = 1; m_cur = pick; m_left = m_cnt[pick] + 1; end
          else if (m_miss < 255) m_miss++;
        end
      end
      if (cfg_we) begin
        m_valid[cfg_idx] = cfg_valid; m_off[cfg_idx] = cfg_offset;
        m_cnt[cfg_idx] = cfg_burst; m_mac[cfg_idx] = cfg_dst_mac; m_vid[cfg_idx] = cfg_vid;
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    #1;
    begin
      bit ok;
      bit e_disc;
      bit e_err;
      e_disc = 0; e_err = 0;
      foreach (m_valid[i]) if (m_valid[i]) begin
        e_disc = 1;
        if (m_off[i] >= cycle_time) e_err = 1;
      end
      ok = 1;
      vectors++;
      if (fetch_req !== m_req) begin
        ok = 0; $display("FAIL %s fetch_req actual %0b expected %0b at %0t", phase, fetch_req, m_req, $time);
      end else if (m_req && (fetch_idx !== 3'(m_idx) || fetch_mac !== m_omac || fetch_vid !== m_ovid)) begin
        ok = 0; $display("FAIL %s request fields actual %0d/%h/%0d expected %0d/%h/%0d", phase,
                         fetch_idx, fetch_mac, fetch_vid, m_idx, m_omac, m_ovid);
      end
      if (miss_count !== 8'(m_miss)) begin
        ok = 0; $display("FAIL %s miss_count actual %0d expected %0d", phase, miss_count, m_miss);
      end
      if (discrete_mode !== e_disc) begin
        ok = 0; $display("FAIL %s discrete_mode actual %0b expected %0b", phase, discrete_mode, e_disc);
      end
      if (cfg_err !== e_err) begin
        ok = 0; $display("FAIL %s cfg_err actual %0b expected %0b", phase, cfg_err, e_err);
      end
      if (!ok) miscompares++;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit cond, input string tag, input string what, input int act, input int exp);
    vectors++;
    if (!cond) begin
      miscompares++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic write_entry(input int idx, input bit v, input int unsigned off,
                             input int burst_m1, input logic [47:0] mac, input logic [11:0] vid);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_valid = v; cfg_offset = off;
    cfg_burst = 2'(burst_m1); cfg_dst_mac = mac; cfg_vid = vid;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_cycles(input int n);
    repeat (n * CYC_CLKS) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #900_000;
    miscompares++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check(fetch_req == 0, "R1", "fetch_req after reset", fetch_req, 0);
    check(miss_count == 0, "R1", "miss_count after reset", miss_count, 0);
    check(discrete_mode == 0, "R1", "discrete_mode after reset", discrete_mode, 0);
    rst_n = 1;

    // continuous fetching with a waiting-frame pattern
    phase = "R2"; cont_toggle = 1; drv_on = 1;
    run_cycles(2);
    cont_toggle = 0;

    // first stream: 3 frames at 200 ns
    phase = "R3";
    write_entry(0, 1, 200, 2, 48'h0A_00_00_00_00_01, 12'd10);
    #1 check(discrete_mode == 1, "R3", "discrete_mode after write", discrete_mode, 1);
    phase = "R4"; run_cycles(1);
    phase = "R5"; run_cycles(1);

    // second stream at the same offset, 2 frames
    phase = "R8";
    write_entry(1, 1, 200, 1, 48'h0A_00_00_00_00_02, 12'd20);
    run_cycles(2);

    // frame availability gaps on stream 0
    phase = "R11"; fa_toggle = 1;
    run_cycles(2);
    fa_toggle = 0;

    // burst truncated by the gate closing at 600 ns
    phase = "R7";
    write_entry(4, 1, 580, 3, 48'h0A_00_00_00_00_04, 12'd40);
    run_cycles(2);

    // offset beyond the cycle
    phase = "R9";
    write_entry(3, 1, 1500, 0, 48'h0A_00_00_00_00_03, 12'd30);
    run_cycles(1);
    #1 check(cfg_err == 1, "R9", "cfg_err with out-of-range entry", cfg_err, 1);

    // burst cut by the cycle-start pulse
    phase = "R10"; g_hi = 1000;
    write_entry(5, 1, 970, 3, 48'h0A_00_00_00_00_05, 12'd50);
    run_cycles(2);
    write_entry(5, 0, 970, 3, 48'h0A_00_00_00_00_05, 12'd50);
    g_hi = 600;

    // trigger on a closed gate, run into saturation
    phase = "R6";
    write_entry(2, 1, 50, 0, 48'h0A_00_00_00_00_06, 12'd60);
    run_cycles(260);
    #1 check(miss_count == 8'd255, "R6", "saturated miss_count", miss_count, 255);

    // empty the table: back to continuous
    phase = "R2";
    for (int i = 0; i < 8; i++) write_entry(i, 0, 0, 0, '0, '0);
    #1 check(discrete_mode == 0, "R2", "discrete_mode with empty table", discrete_mode, 0);
    run_cycles(1);

    finish_run();
  end

endmodule